// File: doc/BRIEF.md
# Bus Wake-Up Pulse Qualifier

This block sits beside the mode controller of a single-wire vehicle bus node. While the node rests in one of its low-power modes it watches the digitized bus level and decides whether activity on the bus is a genuine remote wake request. A request is accepted only when the bus goes through a full cycle: a falling edge to dominant, a dominant phase that lasts longer than a programmable filter time, and a return to recessive. The block answers with a single one-cycle pulse, issued right after that return.

Time is measured in ticks of an external timebase strobe, so the filter length is independent of the clock rate. Two saturating counters track the dominant phase. The first counts to the filter limit. The second counts further, to a stuck limit, which marks a bus held low by a short to ground. A short of that kind never yields a wake. The next clean sequence after the short clears does. When the node is in the silent low-power mode, a wake is honoured only while the transmit-data line is high. In the deeper sleep mode that line has no effect on the decision.

Top module: `bus_wake_qualifier`

## Requirements
- R1: While reset is held and in the cycles after it, `wakePulse` is 0, and no wake occurs until a falling edge of `busRx` (1 = recessive, 0 = dominant) has been seen with `lowPowerArm` high.
- R2: After an armed falling edge, let T be the number of cycles with `tickEn` high in which `busRx` is sampled 0, not counting the cycle of the edge itself. If FILTER_TICKS <= T <= FILTER_TICKS+STUCK_TICKS-1, then `wakePulse` is high in the cycle after the rising edge of `busRx` is sampled.
- R3: A dominant phase with T < FILTER_TICKS produces no wake, and it does not prevent the next valid sequence from waking.
- R4: No wake is issued while the bus is still dominant. A long dominant level by itself never produces a pulse; only the rising edge does.
- R5: A dominant phase with T >= FILTER_TICKS+STUCK_TICKS (a bus short) produces no wake on its rising edge. The next valid sequence after it wakes normally.
- R6: With `silentMode` = 1, a wake is issued only if `txdLevel` = 1 in the rising-edge cycle. With `silentMode` = 0, `txdLevel` has no effect.
- R7: Falling edges seen while `lowPowerArm` is 0 are ignored. Dropping `lowPowerArm` during a dominant phase abandons that phase without a wake.
- R8: If the bus is already dominant when `lowPowerArm` rises, the later rising edge does not produce a wake, because no armed falling edge started the measurement.
- R9: Cycles with `tickEn` = 0 do not advance the measurement. Only timebase ticks count toward the filter and stuck limits.
- R10: Every wake is exactly one clock cycle wide.
- R11: Both counters saturate at their limits, so an arbitrarily long dominant phase never wraps back into the valid window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowPowerArm | input | 1 | High while the node is in a low-power mode and the pre-wake detector has enabled the receiver |
| silentMode | input | 1 | 1 = silent low-power mode, 0 = sleep mode |
| txdLevel | input | 1 | Level of the transmit-data line |
| tickEn | input | 1 | Timebase strobe; one pulse per filter tick |
| busRx | input | 1 | Digitized bus level, 1 = recessive, 0 = dominant |
| wakePulse | output | 1 | One-cycle remote wake request to the mode controller |

## Verification
The bench builds the block with FILTER_TICKS = 4 and STUCK_TICKS = 6. With these values the shortest accepted pulse, the longest accepted pulse and the first pulse treated as a short are all a few cycles long, and a single run can check both edges of the valid window exactly. The small limits also let the bench thin out the timebase strobe, which shows that ticks, not clock cycles, set the window. Both counters are driven into saturation by a dominant phase several times longer than their combined limit.

// File: rtl/wakeq_pkg.sv
`timescale 1ns/1ps
package wakeq_pkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_MEASURE = 1'b1
  } wakeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;   // hold both counters at zero
    logic measure;  // a dominant phase is being timed
  } wakeStrobe_t;

endpackage

// File: rtl/wakeq_datapath.sv
`timescale 1ns/1ps
module wakeq_datapath
  import wakeq_pkg::*;
#(
  parameter int FILTER_TICKS = 100,
  parameter int STUCK_TICKS  = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busRx,
  input  logic        tickEn,
  input  wakeStrobe_t strobe,
  output logic        fallEdge,
  output logic        riseEdge,
  output logic        filtDone,
  output logic        stuckDone
);

  localparam int FW = $clog2(FILTER_TICKS + 1);
  localparam int SW = $clog2(STUCK_TICKS + 1);
  localparam logic [FW-1:0] FILT_MAX  = FW'(FILTER_TICKS);
  localparam logic [SW-1:0] STUCK_MAX = SW'(STUCK_TICKS);

  logic          busPrev;
  logic [FW-1:0] filtCnt;
  logic [SW-1:0] stuckCnt;
  logic          countEn;

  always_ff @(posedge clk) begin
    if (!rstN) busPrev <= 1'b1;
    else       busPrev <= busRx;
  end

  assign fallEdge = busPrev & ~busRx;
  assign riseEdge = ~busPrev & busRx;

  assign countEn   = strobe.measure & tickEn & ~busRx;
  assign filtDone  = (filtCnt == FILT_MAX);
  assign stuckDone = (stuckCnt == STUCK_MAX);

  // filter counter, saturating at the filter limit
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrCnt)        filtCnt <= '0;
    else if (countEn && !filtDone)     filtCnt <= filtCnt + 1'b1;
  end

  // stuck counter, runs only once the filter limit is reached
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrCnt)               stuckCnt <= '0;
    else if (countEn && filtDone && !stuckDone) stuckCnt <= stuckCnt + 1'b1;
  end

  // R11
  filt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (filtDone && !strobe.clrCnt) |=> filtDone);

  // R11
  stuck_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stuckDone && !strobe.clrCnt) |=> stuckDone);

  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobe.clrCnt) |=> ($stable(filtCnt) && $stable(stuckCnt)));

  // R5
  stuck_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stuckCnt != '0) |-> filtDone);

endmodule

// File: rtl/wakeq_control.sv
`timescale 1ns/1ps
module wakeq_control
  import wakeq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowPowerArm,
  input  logic        silentMode,
  input  logic        txdLevel,
  input  logic        fallEdge,
  input  logic        riseEdge,
  input  logic        filtDone,
  input  logic        stuckDone,
  output wakeStrobe_t strobe,
  output logic        wakePulse
);

  wakeState_t state, stateNext;
  logic       txdAllows;
  logic       fire;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (lowPowerArm && fallEdge) stateNext = ST_MEASURE;
      ST_MEASURE: if (!lowPowerArm || riseEdge) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.clrCnt  = (state == ST_IDLE);
  assign strobe.measure = (state == ST_MEASURE);

  // in silent mode the transmit line must be high; sleep ignores it
  assign txdAllows = ~silentMode | txdLevel;
  assign fire = (state == ST_MEASURE) & lowPowerArm & riseEdge &
                filtDone & ~stuckDone & txdAllows;

  always_ff @(posedge clk) begin
    if (!rstN) wakePulse <= 1'b0;
    else       wakePulse <= fire;
  end

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R6
  silent_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> !($past(silentMode) && !$past(txdLevel)));

  // R7
  arm_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $past(lowPowerArm));

  // R7
  disarm_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lowPowerArm |=> (state == ST_IDLE));

  // R2
  wake_after_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> ($past(riseEdge) && $past(filtDone) && !$past(stuckDone)));

endmodule

// File: rtl/bus_wake_qualifier.sv
`timescale 1ns/1ps
module bus_wake_qualifier
  import wakeq_pkg::*;
#(
  parameter int FILTER_TICKS = 100,
  parameter int STUCK_TICKS  = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowPowerArm,
  input  logic silentMode,
  input  logic txdLevel,
  input  logic tickEn,
  input  logic busRx,
  output logic wakePulse
);

  wakeStrobe_t strobe;
  logic fallEdge, riseEdge, filtDone, stuckDone;

  wakeq_datapath #(
    .FILTER_TICKS(FILTER_TICKS),
    .STUCK_TICKS (STUCK_TICKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busRx    (busRx),
    .tickEn   (tickEn),
    .strobe   (strobe),
    .fallEdge (fallEdge),
    .riseEdge (riseEdge),
    .filtDone (filtDone),
    .stuckDone(stuckDone)
  );

  wakeq_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .lowPowerArm(lowPowerArm),
    .silentMode (silentMode),
    .txdLevel   (txdLevel),
    .fallEdge   (fallEdge),
    .riseEdge   (riseEdge),
    .filtDone   (filtDone),
    .stuckDone  (stuckDone),
    .strobe     (strobe),
    .wakePulse  (wakePulse)
  );

  // R4
  wake_on_recessive_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $past(busRx));

endmodule

// File: tb/sim_bus_wake_qualifier.sv
`timescale 1ns/1ps
module sim_bus_wake_qualifier;

  localparam int F = 4;
  localparam int S = 6;

  logic clk = 1'b0;
  logic rstN, lowPowerArm, silentMode, txdLevel, tickEn, busRx;
  logic wakePulse;

  int checks = 0;
  int failures = 0;
  int wakeCount = 0;
  int domWakeTotal = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_wake_qualifier #(.FILTER_TICKS(F), .STUCK_TICKS(S)) u0 (
    .clk(clk), .rstN(rstN), .lowPowerArm(lowPowerArm), .silentMode(silentMode),
    .txdLevel(txdLevel), .tickEn(tickEn), .busRx(busRx), .wakePulse(wakePulse)
  );

  always @(negedge clk) if (wakePulse) wakeCount++;

  typedef struct packed {
    logic       sil;
    logic       txd;
    logic [7:0] dom;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b0, 1'b0, 8'd5,  1'b1},
    '{1'b0, 1'b1, 8'd4,  1'b0},
    '{1'b0, 1'b1, 8'd6,  1'b1},
    '{1'b0, 1'b0, 8'd10, 1'b1},
    '{1'b0, 1'b0, 8'd11, 1'b0},
    '{1'b0, 1'b0, 8'd30, 1'b0},
    '{1'b0, 1'b1, 8'd7,  1'b1},
    '{1'b1, 1'b1, 8'd5,  1'b1},
    '{1'b1, 1'b0, 8'd7,  1'b0},
    '{1'b0, 1'b0, 8'd2,  1'b0},
    '{1'b1, 1'b1, 8'd10, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // dominant for dom cycles; tick on cycle i (1..dom-1) when i%every==0
  task automatic runPulse(input int dom, input int every,
                          output int wakes, output int wakesDom);
    int start;
    #1 start = wakeCount;
    for (int i = 0; i < dom; i++) begin
      @(negedge clk);
      busRx  = 1'b0;
      tickEn = (i >= 1) && (i % every == 0);
    end
    @(negedge clk);
    busRx  = 1'b1;
    tickEn = 1'b1;
    #1 wakesDom = wakeCount - start;
    repeat (4) @(negedge clk);
    #1 wakes = wakeCount - start;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w, wd, s;
    string tag;
    rstN = 1'b0; lowPowerArm = 1'b0; silentMode = 1'b0;
    txdLevel = 1'b1; tickEn = 1'b1; busRx = 1'b1;
    idle(3);
    #1 check(wakePulse == 1'b0, "R1 wake low in reset", wakePulse, 0);
    @(negedge clk); rstN = 1'b1;
    idle(3);
    #1 check(wakeCount == 0, "R1 no wake after reset", wakeCount, 0);

    lowPowerArm = 1'b1;
    idle(2);

    // table walk
    for (int r = 0; r < 11; r++) begin
      silentMode = VEC[r].sil;
      txdLevel   = VEC[r].txd;
      runPulse(int'(VEC[r].dom), 1, w, wd);
      domWakeTotal += wd;
      if (VEC[r].sil) tag = "R6";
      else if (VEC[r].dom <= F) tag = "R3";
      else if (VEC[r].dom > F + S) tag = "R5";
      else tag = "R2";
      check(w == int'(VEC[r].exp), $sformatf("%s row %0d wake count", tag, r), w, int'(VEC[r].exp));
      idle(3);
    end
    check(domWakeTotal == 0, "R4 no wake while dominant", domWakeTotal, 0);
    silentMode = 1'b0; txdLevel = 1'b1;

    // R10: single valid pulse yields exactly one high sample
    runPulse(F + 2, 1, w, wd);
    check(w == 1, "R10 pulse width one cycle", w, 1);
    idle(3);

    // R11: very long dominant phase, counters must not wrap into window
    runPulse(120, 1, w, wd);
    check(w == 0, "R11 long dominant no wrap", w, 0);
    idle(3);

    // R9: thinned timebase, ticks every third cycle
    runPulse(13, 3, w, wd);
    check(w == 1, "R9 four ticks in 13 cycles wakes", w, 1);
    idle(3);
    runPulse(12, 3, w, wd);
    check(w == 0, "R9 three ticks in 12 cycles no wake", w, 0);
    idle(3);
    runPulse(8, 100, w, wd);
    check(w == 0, "R9 no ticks no wake", w, 0);
    idle(3);

    // R7: unarmed pulse ignored
    lowPowerArm = 1'b0;
    runPulse(F + 2, 1, w, wd);
    check(w == 0, "R7 unarmed pulse ignored", w, 0);
    idle(3);

    // R7: disarm in the middle of a dominant phase
    lowPowerArm = 1'b1;
    #1 s = wakeCount;
    @(negedge clk); busRx = 1'b0;
    idle(3);
    lowPowerArm = 1'b0;
    idle(2);
    lowPowerArm = 1'b1;
    idle(5);
    busRx = 1'b1;
    idle(4);
    #1 check(wakeCount - s == 0, "R7 disarm mid pulse aborts", wakeCount - s, 0);

    // R8: bus already dominant when armed
    lowPowerArm = 1'b0;
    #1 s = wakeCount;
    @(negedge clk); busRx = 1'b0;
    idle(2);
    lowPowerArm = 1'b1;
    idle(8);
    busRx = 1'b1;
    idle(4);
    #1 check(wakeCount - s == 0, "R8 pre-dominant release no wake", wakeCount - s, 0);
    idle(2);
    runPulse(F + 1, 1, w, wd);
    check(w == 1, "R8 next clean pulse wakes", w, 1);
    idle(3);

    // R6: sleep mode ignores transmit level
    silentMode = 1'b0; txdLevel = 1'b0;
    runPulse(F + 3, 1, w, wd);
    check(w == 1, "R6 sleep txd low still wakes", w, 1);
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule